// File: doc/BRIEF.md
# Real-Time Clock Alarm and Interrupt Controller

This block watches the running calendar time and raises interrupts when it reaches programmed alarm times. The time arrives as BCD values from counters outside the block: a day-of-week index, an hour byte and a minute byte. Two alarms are held in registers. The weekly alarm compares day-of-week, hour and minute. The daily alarm compares only hour and minute.

Each alarm has a sticky flag and an enable bit. The weekly alarm drives the active-low output `int_b_n_o`. The daily alarm drives the active-low output `int_a_n_o`. A periodic tick from an external prescaler shares `int_a_n_o` with the daily alarm, and the two sources are combined so that either one can pull the pin low. A 3-bit code turns the periodic source off or selects pulse or level behaviour. Software reads the flags to find out which source is active and clears them by writing zeros.

All registers sit behind a single 8-bit data port with a 4-bit address. Reads return the addressed register one cycle later.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The weekly flag (status bit 1) sets, and `int_b_n_o` goes low, when the current day-of-week, hour and minute equal the weekly alarm registers (address 0 minute, 1 hour, 2 day-of-week).
- R2: The daily flag (status bit 0) sets, and `int_a_n_o` goes low, when the current hour and minute equal the daily alarm registers (address 3 minute, 4 hour), whatever the day-of-week.
- R3: Each alarm output is low exactly while both its flag and its enable are 1. Clearing the enable releases the output and leaves the flag unchanged.
- R4: An alarm flag sets only in the cycle where its match becomes true. It stays set until it is cleared, and a match that continues after clearing does not set it again.
- R5: The status register is at address Fh (bit 2 periodic, bit 1 weekly, bit 0 daily). Writing 0 to a flag bit clears it, and writing 1 has no effect.
- R6: With periodic code 000 a tick sets no flag and leaves `int_a_n_o` unaffected.
- R7: After reset both outputs are high and every register reads 0.
- R8: An alarm flag does not set while its enable bit is 0.
- R9: Periodic codes 100 to 111 select level mode. A tick sets the periodic flag, and `int_a_n_o` stays low until the flag is cleared.
- R10: Periodic codes 001 to 011 select pulse mode. Each tick sets the periodic flag and drives `int_a_n_o` low for PULSE_CYC cycles, after which the output releases by itself.
- R11: `int_a_n_o` is low whenever the daily alarm or the periodic source asserts it. Clearing one flag leaves the output low while the other source is still active.
- R12: The control register is at address Eh, with the weekly enable at bit 7, the daily enable at bit 6 and the periodic code at bits 2..0. The control register and the alarm registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_dow_i | input | DOW_W | Current day-of-week index |
| cur_hour_i | input | 8 | Current hour, BCD |
| cur_min_i | input | 8 | Current minute, BCD |
| per_tick_i | input | 1 | One-cycle periodic tick from the prescaler |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| int_a_n_o | output | 1 | Daily alarm / periodic interrupt, active low |
| int_b_n_o | output | 1 | Weekly alarm interrupt, active low |

## Verification
The hardest case to reach is a second, separate rising edge of a match. Flags set only on an edge, so every sweep point first parks the time on an hour value that cannot match, then clears the flags, and only then applies the point under test. This gives each of the 504 day/hour/minute combinations a fresh edge that can be compared against the arithmetic expectation. The shared output A is reached with both of its sources active at once: a held daily match plus a level-mode tick. The flags are then cleared one at a time to show that the output is combined.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_WK_MIN = 4'h0;
  localparam logic [ADDR_W-1:0] A_WK_HR  = 4'h1;
  localparam logic [ADDR_W-1:0] A_WK_DOW = 4'h2;
  localparam logic [ADDR_W-1:0] A_DY_MIN = 4'h3;
  localparam logic [ADDR_W-1:0] A_DY_HR  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'hE;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'hF;

  localparam int CTL_WK_EN = 7;
  localparam int CTL_DY_EN = 6;
  localparam int ST_PER    = 2;
  localparam int ST_WK     = 1;
  localparam int ST_DY     = 0;

  typedef enum logic [1:0] {PER_OFF, PER_PULSE, PER_LEVEL} per_mode_e;

  function automatic per_mode_e decode_mode(input logic [2:0] code);
    if (code == 3'b000)  return PER_OFF;
    else if (code[2])    return PER_LEVEL;
    else                 return PER_PULSE;
  endfunction
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter bit USE_DOW = 1'b1,
  parameter int DOW_W   = 3,
  parameter int FLD_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [DOW_W-1:0] cur_dow_i,
  input  logic [FLD_W-1:0] cur_hour_i,
  input  logic [FLD_W-1:0] cur_min_i,
  input  logic [DOW_W-1:0] set_dow_i,
  input  logic [FLD_W-1:0] set_hour_i,
  input  logic [FLD_W-1:0] set_min_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic hm_eq;
  logic eq;
  logic eq_q;

  assign hm_eq = (cur_hour_i == set_hour_i) && (cur_min_i == set_min_i);

  generate
    if (USE_DOW) begin : g_weekly
      assign eq = hm_eq && (cur_dow_i == set_dow_i);
    end else begin : g_daily
      logic unused_dow;
      assign unused_dow = ^{cur_dow_i, set_dow_i};
      assign eq = hm_eq;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      eq_q   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      eq_q <= eq;
      if (eq && !eq_q && enable_i) flag_o <= 1'b1;
      else if (clr_i)              flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_periodic_src.sv
module rtc_periodic_src
  import rtc_irq_pkg::*;
#(
  parameter int PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [2:0] code_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       drive_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  per_mode_e        mode;
  logic [CNT_W-1:0] cnt;

  assign mode = decode_mode(code_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      cnt    <= '0;
    end else begin
      if (tick_i && mode != PER_OFF) flag_o <= 1'b1;
      else if (clr_i)                flag_o <= 1'b0;

      if (mode != PER_PULSE) cnt <= '0;
      else if (tick_i)       cnt <= CNT_W'(PULSE_CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assign drive_o = ((mode == PER_LEVEL) && flag_o) ||
                   ((mode == PER_PULSE) && (cnt != '0));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int DOW_W     = 3,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOW_W-1:0]  cur_dow_i,
  input  logic [7:0]        cur_hour_i,
  input  logic [7:0]        cur_min_i,
  input  logic              per_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              int_a_n_o,
  output logic              int_b_n_o
);
  localparam int PAD_W = DATA_W - DOW_W;

  logic [7:0]       wk_min, wk_hr, dy_min, dy_hr;
  logic [DOW_W-1:0] wk_dow;
  logic             wk_en, dy_en;
  logic [2:0]       per_code;
  logic             wk_flag, dy_flag, per_flag, per_drive;
  logic             stat_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_min   <= '0;
      wk_hr    <= '0;
      wk_dow   <= '0;
      dy_min   <= '0;
      dy_hr    <= '0;
      wk_en    <= 1'b0;
      dy_en    <= 1'b0;
      per_code <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_WK_MIN: wk_min <= reg_wdata_i;
        A_WK_HR:  wk_hr  <= reg_wdata_i;
        A_WK_DOW: wk_dow <= reg_wdata_i[DOW_W-1:0];
        A_DY_MIN: dy_min <= reg_wdata_i;
        A_DY_HR:  dy_hr  <= reg_wdata_i;
        A_CTRL: begin
          wk_en    <= reg_wdata_i[CTL_WK_EN];
          dy_en    <= reg_wdata_i[CTL_DY_EN];
          per_code <= reg_wdata_i[2:0];
        end
        default: ;
      endcase
    end
  end

  assign stat_wr = reg_wr_i && (reg_addr_i == A_STAT);

  rtc_alarm_match #(.USE_DOW(1'b1), .DOW_W(DOW_W), .FLD_W(8)) u_weekly (
    .clk(clk), .rst(rst), .enable_i(wk_en),
    .cur_dow_i(cur_dow_i), .cur_hour_i(cur_hour_i), .cur_min_i(cur_min_i),
    .set_dow_i(wk_dow), .set_hour_i(wk_hr), .set_min_i(wk_min),
    .clr_i(stat_wr && !reg_wdata_i[ST_WK]), .flag_o(wk_flag)
  );

  rtc_alarm_match #(.USE_DOW(1'b0), .DOW_W(DOW_W), .FLD_W(8)) u_daily (
    .clk(clk), .rst(rst), .enable_i(dy_en),
    .cur_dow_i(cur_dow_i), .cur_hour_i(cur_hour_i), .cur_min_i(cur_min_i),
    .set_dow_i(wk_dow), .set_hour_i(dy_hr), .set_min_i(dy_min),
    .clr_i(stat_wr && !reg_wdata_i[ST_DY]), .flag_o(dy_flag)
  );

  rtc_periodic_src #(.PULSE_CYC(PULSE_CYC)) u_periodic (
    .clk(clk), .rst(rst), .tick_i(per_tick_i), .code_i(per_code),
    .clr_i(stat_wr && !reg_wdata_i[ST_PER]),
    .flag_o(per_flag), .drive_o(per_drive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
      int_a_n_o   <= 1'b1;
      int_b_n_o   <= 1'b1;
    end else begin
      int_b_n_o <= !(wk_flag && wk_en);
      int_a_n_o <= !((dy_flag && dy_en) || per_drive);
      case (reg_addr_i)
        A_WK_MIN: reg_rdata_o <= wk_min;
        A_WK_HR:  reg_rdata_o <= wk_hr;
        A_WK_DOW: reg_rdata_o <= {{PAD_W{1'b0}}, wk_dow};
        A_DY_MIN: reg_rdata_o <= dy_min;
        A_DY_HR:  reg_rdata_o <= dy_hr;
        A_CTRL:   reg_rdata_o <= {wk_en, dy_en, 3'b000, per_code};
        A_STAT:   reg_rdata_o <= {5'b00000, per_flag, wk_flag, dy_flag};
        default:  reg_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr_i,
  input logic [3:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       int_a_n_o,
  input logic       int_b_n_o,
  input logic       wk_en,
  input logic       dy_en,
  input logic       wk_flag,
  input logic       dy_flag,
  input logic       per_flag,
  input logic [2:0] per_code
);
  p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (int_a_n_o && int_b_n_o));

  p_b_gated_r3: assert property (@(posedge clk) disable iff (rst)
    !wk_en |=> int_b_n_o);

  p_a_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!dy_en && per_code == 3'b000) |=> int_a_n_o);

  p_wk_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (wk_flag && !(reg_wr_i && reg_addr_i == 4'hF && !reg_wdata_i[1])) |=> wk_flag);

  p_dy_noset_r8: assert property (@(posedge clk) disable iff (rst)
    (!dy_en && !dy_flag) |=> !dy_flag);

  p_per_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(per_flag) |-> $past(per_code) != 3'b000);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .int_a_n_o(int_a_n_o), .int_b_n_o(int_b_n_o),
  .wk_en(wk_en), .dy_en(dy_en), .wk_flag(wk_flag), .dy_flag(dy_flag),
  .per_flag(per_flag), .per_code(per_code)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  localparam int DOW_W = 3;
  localparam int PCYC  = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DOW_W-1:0] dow = '0;
  logic [7:0]       hr = 8'h99, mn = 8'h00;
  logic             tick = 1'b0;
  logic [3:0]       addr = '0;
  logic             wr = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic             a_n, b_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rtc_alarm_irq #(.DOW_W(DOW_W), .PULSE_CYC(PCYC)) dut (
    .clk(clk), .rst(rst), .cur_dow_i(dow), .cur_hour_i(hr), .cur_min_i(mn),
    .per_tick_i(tick), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .int_a_n_o(a_n), .int_b_n_o(b_n)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; wr = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rreg(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic expect_pins(input bit ea, input bit eb, input string req);
    check(a_n == ea, {req, " A"}, {7'd0, a_n}, {7'd0, ea});
    check(b_n == eb, {req, " B"}, {7'd0, b_n}, {7'd0, eb});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    settle(2);
    // R7: reset state
    expect_pins(1'b1, 1'b1, "R7 reset");
    for (int a = 0; a < 16; a++) expect_reg(4'(a), 8'h00, "R7 reset reg");

    // R12: program alarms and control, read back
    wreg(4'h0, 8'h34); wreg(4'h1, 8'h12); wreg(4'h2, 8'h03);
    wreg(4'h3, 8'h35); wreg(4'h4, 8'h12);
    wreg(4'hE, 8'hC0);
    expect_reg(4'h0, 8'h34, "R12 wk min");
    expect_reg(4'h1, 8'h12, "R12 wk hr");
    expect_reg(4'h2, 8'h03, "R12 wk dow");
    expect_reg(4'h3, 8'h35, "R12 dy min");
    expect_reg(4'h4, 8'h12, "R12 dy hr");
    expect_reg(4'hE, 8'hC0, "R12 ctrl");

    // R1 R2: sweep day/hour/minute, expected match computed arithmetically
    for (int d = 0; d < 7; d++) begin
      for (int h = 0; h < 24; h++) begin
        for (int m = 33; m <= 35; m++) begin
          bit eb, ea;
          hr = 8'h99;
          settle(1);
          wreg(4'hF, 8'h00);
          dow = DOW_W'(d); hr = bcd(h); mn = bcd(m);
          settle(3);
          eb = (d == 3) && (h == 12) && (m == 34);
          ea = (h == 12) && (m == 35);
          check(b_n == !eb, "R1 weekly pin", {7'd0, b_n}, {7'd0, !eb});
          check(a_n == !ea, "R2 daily pin", {7'd0, a_n}, {7'd0, !ea});
          expect_reg(4'hF, {6'd0, eb, ea}, "R1 R2 flags");
        end
      end
    end

    // R4: held match after clear does not re-set
    hr = 8'h99; settle(1); wreg(4'hF, 8'h00);
    dow = 3'd3; hr = 8'h12; mn = 8'h34; settle(3);
    expect_pins(1'b1, 1'b0, "R4 set");
    wreg(4'hF, 8'h00); settle(3);
    expect_pins(1'b1, 1'b1, "R4 held match after clear");
    expect_reg(4'hF, 8'h00, "R4 no reset of flag");

    // R3: clearing enable releases pin, keeps flag
    hr = 8'h99; settle(1);
    dow = 3'd3; hr = 8'h12; mn = 8'h34; settle(3);
    expect_pins(1'b1, 1'b0, "R3 low");
    wreg(4'hE, 8'h40); settle(2);
    expect_pins(1'b1, 1'b1, "R3 enable off");
    expect_reg(4'hF, 8'h02, "R3 flag kept");
    wreg(4'hE, 8'hC0); settle(2);
    expect_pins(1'b1, 1'b0, "R3 enable back");

    // R5: writing 1 keeps, writing 0 clears
    wreg(4'hF, 8'hFF); settle(2);
    expect_reg(4'hF, 8'h02, "R5 write one no effect");
    wreg(4'hF, 8'hFD); settle(2);
    expect_reg(4'hF, 8'h00, "R5 write zero clears");
    expect_pins(1'b1, 1'b1, "R5 released");

    // R8: disabled alarm does not set its flag
    wreg(4'hE, 8'h00);
    hr = 8'h99; settle(1);
    dow = 3'd3; hr = 8'h12; mn = 8'h34; settle(3);
    expect_reg(4'hF, 8'h00, "R8 weekly disabled");
    hr = 8'h99; settle(1);
    mn = 8'h35; hr = 8'h12; settle(3);
    expect_reg(4'hF, 8'h00, "R8 daily disabled");
    expect_pins(1'b1, 1'b1, "R8 pins");

    // R6: code 000 ignores ticks
    hr = 8'h99;
    do_tick(); settle(2);
    expect_reg(4'hF, 8'h00, "R6 no flag");
    expect_pins(1'b1, 1'b1, "R6 pins");

    // R10: pulse mode, code 010
    wreg(4'hE, 8'h02);
    do_tick();
    for (int k = 1; k <= PCYC + 1; k++) begin
      @(negedge clk);
      check(a_n == (k > PCYC), "R10 pulse shape", {7'd0, a_n}, {7'd0, k > PCYC});
    end
    settle(5);
    expect_pins(1'b1, 1'b1, "R10 released");
    expect_reg(4'hF, 8'h04, "R10 flag");
    wreg(4'hF, 8'h00);

    // R9: level mode, code 101
    wreg(4'hE, 8'h05);
    do_tick(); settle(20);
    expect_pins(1'b0, 1'b1, "R9 level held");
    expect_reg(4'hF, 8'h04, "R9 flag");
    wreg(4'hF, 8'h03); settle(2);
    expect_pins(1'b1, 1'b1, "R9 cleared");

    // R11: daily alarm and level periodic combined on A
    wreg(4'hE, 8'h45);
    hr = 8'h99; settle(1);
    hr = 8'h12; mn = 8'h35; settle(3);
    do_tick(); settle(2);
    expect_pins(1'b0, 1'b1, "R11 both");
    expect_reg(4'hF, 8'h05, "R11 flags");
    wreg(4'hF, 8'h06); settle(2);
    expect_pins(1'b0, 1'b1, "R11 periodic still");
    expect_reg(4'hF, 8'h04, "R11 daily cleared");
    wreg(4'hF, 8'h00); settle(2);
    expect_pins(1'b1, 1'b1, "R11 all clear");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule